// File: doc/BRIEF.md
# Tile Startup Sequencer with Self-Repair

This block brings one logic tile out of its power-on isolation and then keeps it there safely. After reset, every user flip-flop in the tile is isolated (its data input is forced low), held in forced reset and left without a clock. A start command arms a five-stage bit chain. The chain fills with ones at one stage per clock. Each stage releases one tile-wide control, so the controls come free in a fixed order. Once all five stages hold one, the tile is in normal operation and the chain stops shifting.

Each stage drives its control directly. A single upset stage therefore acts on every user flip-flop of the tile at once, from the next clock edge. A built-in watchdog compares the chain against all ones at a fixed check interval. If it finds a corrupted stage, it clears the chain, holds the tile isolated and replays the start sequence. Repair finishes within a parameterised time limit, `LIMIT_US` microseconds at `CLK_MHZ`. The `strike_i` pins inject single-stage upsets for test and are tied low in use. All pins are plain control levels. Since no data stream passes through the block, no valid/ready handshake applies and nothing can exert back-pressure.

Top module: `tile_seq_repair`

## Requirements
- R1: During reset, and after reset for as long as no start is given, the outputs sit in the isolated state. In that state tile_iso_o=1, tile_clk_en_o=0, tile_force_rst_o=1, tile_force_set_o=0 and tile_ready_o=0.
- R2: A start pulse sampled at clock edge E0 arms the chain. From E1 on, one stage loads per edge, in the order set-release (stage 0), reset-release (1), clock-enable (2), isolation-release (3), ready (4). The outputs change as follows: tile_force_rst_o falls after E2, tile_clk_en_o rises after E3, tile_iso_o falls after E4 and tile_ready_o rises after E5.
- R3: A start given while the sequencer is already armed has no effect on the outputs.
- R4: Once every stage holds one, the stages stop shifting. If no upset occurs, the outputs stay in the normal state (iso 0, clk_en 1, force_rst 0, force_set 0, ready 1) indefinitely.
- R5: A one on strike_i[k] at an edge inverts stage k. The corrupted stage acts on its control from that edge on: stage 0 asserts tile_force_set_o, stage 1 asserts tile_force_rst_o, stage 2 drops tile_clk_en_o, stage 3 asserts tile_iso_o and stage 4 drops tile_ready_o.
- R6: The chain is compared against all ones once every CHK = CLK_MHZ*LIMIT_US-6 cycles of normal operation. The interval is counted from the edge at which the tile last came up. A fault seen at a check clears the chain and puts the outputs in the isolated state after that edge. Until then, the corrupted outputs of R5 remain.
- R7: From the clearing edge, the outputs stay isolated for five further edges while the chain reloads. They return to normal after the sixth edge.
- R8: From the upset edge to the return to normal, no more than CLK_MHZ*LIMIT_US cycles pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tile clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start command; arms the sequencer |
| strike_i | input | 5 | Upset injection, one bit per stage; tie to zero in use |
| tile_iso_o | output | 1 | Forces every user flip-flop data input low |
| tile_clk_en_o | output | 1 | Clock enable for every user flip-flop |
| tile_force_rst_o | output | 1 | Forces every user flip-flop to zero |
| tile_force_set_o | output | 1 | Forces every user flip-flop to one |
| tile_ready_o | output | 1 | Tile in normal operation |

## Verification
The assertions watch several properties on every cycle. Repair starts only when the chain is found faulty and ends only with a full chain. A cleared chain is empty on the next cycle, and a settled chain does not move without an upset. The outputs stay isolated for the whole repair, and the time since the last upset never exceeds the repair budget. Some things only the bench scenarios can show: the exact release order after start, the per-stage effect of each upset, and the check phase. The bench demonstrates the phase by sweeping every stage against every strike offset inside the check interval, including the offset that coincides with a check and so waits a full extra interval.

// File: rtl/tile_seq_pkg.sv
package tile_seq_pkg;
  localparam int NSTG    = 5;
  localparam int IDX_SET = 0;  // set-release stage
  localparam int IDX_RST = 1;  // reset-release stage
  localparam int IDX_CLK = 2;  // clock-enable stage
  localparam int IDX_ISO = 3;  // isolation-release stage
  localparam int IDX_RDY = 4;  // ready stage
  typedef logic [NSTG-1:0] stg_t;
endpackage

// File: rtl/tile_seq_chain.sv
module tile_seq_chain
  import tile_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic shift_en,
  input  logic clear,
  input  stg_t strike,
  output stg_t stg
);
  for (genvar i = 0; i < NSTG; i++) begin : g_stage
    logic prev;
    if (i == 0) begin : g_head
      assign prev = armed;
    end else begin : g_link
      assign prev = stg[i-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n || clear) stg[i] <= 1'b0;
      else if (shift_en)   stg[i] <= prev ^ strike[i];
      else                 stg[i] <= stg[i] ^ strike[i];
    end
  end

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (stg == '0)); // R7
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !clear && strike == '0) |=> $stable(stg)); // R4
endmodule

// File: rtl/tile_seq_watch.sv
module tile_seq_watch #(
  parameter int CHK = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic all_one,
  output logic armed,
  output logic up,
  output logic fix,
  output logic clear
);
  localparam int CW = $clog2(CHK + 1);
  logic [CW-1:0] cnt;
  logic run, tick;

  assign run   = up && !fix;
  assign tick  = run && (cnt == CW'(CHK - 1));
  assign clear = tick && !all_one;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      up    <= 1'b0;
      fix   <= 1'b0;
      cnt   <= '0;
    end else begin
      armed <= armed | start;
      up    <= up | all_one;
      if (clear)              fix <= 1'b1;
      else if (fix && all_one) fix <= 1'b0;
      if (!run || tick) cnt <= '0;
      else              cnt <= cnt + 1'b1;
    end
  end

  AST_FIX_ONLY_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fix) |-> $past(!all_one)); // R6
  AST_FIX_ENDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fix) |-> $past(all_one)); // R7
  AST_UP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    up |=> up); // R4
endmodule

// File: rtl/tile_seq_outmap.sv
module tile_seq_outmap
  import tile_seq_pkg::*;
(
  input  stg_t stg,
  input  logic hold,
  output logic iso,
  output logic clk_en,
  output logic force_rst,
  output logic force_set,
  output logic ready
);
  always_comb begin
    iso       = hold || !stg[IDX_ISO];
    clk_en    = !hold && stg[IDX_CLK];
    force_rst = hold || !stg[IDX_RST];
    force_set = !hold && stg[IDX_RST] && !stg[IDX_SET];
    ready     = !hold && stg[IDX_RDY];
  end
endmodule

// File: rtl/tile_seq_repair.sv
module tile_seq_repair
  import tile_seq_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int LIMIT_US = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [NSTG-1:0] strike_i,
  output logic            tile_iso_o,
  output logic            tile_clk_en_o,
  output logic            tile_force_rst_o,
  output logic            tile_force_set_o,
  output logic            tile_ready_o
);
  localparam int BUDGET = CLK_MHZ * LIMIT_US;
  localparam int CHK    = BUDGET - (NSTG + 1);
  localparam int EW     = $clog2(BUDGET + 2);

  stg_t stg;
  logic armed, up, fix, clear, all_one, shift_en;

  assign all_one  = &stg;
  assign shift_en = armed && (!up || fix);

  tile_seq_chain u_chain (
    .clk(clk), .rst_n(rst_n), .armed(armed), .shift_en(shift_en),
    .clear(clear), .strike(strike_i), .stg(stg)
  );

  tile_seq_watch #(.CHK(CHK)) u_watch (
    .clk(clk), .rst_n(rst_n), .start(start_i), .all_one(all_one),
    .armed(armed), .up(up), .fix(fix), .clear(clear)
  );

  tile_seq_outmap u_map (
    .stg(stg), .hold(fix), .iso(tile_iso_o), .clk_en(tile_clk_en_o),
    .force_rst(tile_force_rst_o), .force_set(tile_force_set_o),
    .ready(tile_ready_o)
  );

  // cycles spent degraded since the most recent upset
  logic [EW-1:0] ep_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || strike_i != '0 || !(up && (fix || !all_one))) ep_cnt <= '0;
    else if (ep_cnt != '1) ep_cnt <= ep_cnt + 1'b1;
  end

  AST_REPAIR_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    ep_cnt <= EW'(BUDGET)); // R8
  AST_ISOLATED_IN_REPAIR: assert property (@(posedge clk) disable iff (!rst_n)
    fix |-> (tile_iso_o && !tile_clk_en_o && tile_force_rst_o && !tile_ready_o)); // R7
endmodule

// File: tb/sim_tile_seq_repair.sv
module sim_tile_seq_repair;
  localparam int MHZ = 1, US = 20;
  localparam int BUD = MHZ * US;
  localparam int CHK = BUD - 6;
  localparam logic [4:0] NORM = 5'b01001;  // {iso,clk_en,rst,set,ready}
  localparam logic [4:0] ISOL = 5'b10100;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [4:0] strike = '0;
  logic iso, cen, frst, fset, rdy;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tile_seq_repair #(.CLK_MHZ(MHZ), .LIMIT_US(US)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .strike_i(strike),
    .tile_iso_o(iso), .tile_clk_en_o(cen), .tile_force_rst_o(frst),
    .tile_force_set_o(fset), .tile_ready_o(rdy)
  );

  function automatic logic [4:0] obs();
    return {iso, cen, frst, fset, rdy};
  endfunction

  function automatic logic [4:0] corrupt(int st);
    case (st)
      0: return NORM | 5'b00010;
      1: return NORM | 5'b00100;
      2: return NORM & ~5'b01000;
      3: return NORM | 5'b10000;
      default: return NORM & ~5'b00001;
    endcase
  endfunction

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(string tag, logic [4:0] exp);
    n_cmp++;
    if (obs() !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, obs(), exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got still running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    chk("R1 in reset", ISOL);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin step(); chk("R1 idle without start", ISOL); end
    start = 1'b1; step(); start = 1'b0;            // E0
    chk("R2 after E0", ISOL);
    step(); chk("R2 after E1", ISOL);
    step(); chk("R2 after E2", 5'b10000);
    step(); chk("R2 after E3", 5'b11000);
    step(); chk("R2 after E4", 5'b01000);
    step(); chk("R2 after E5", NORM);
    step();                                        // E6: check phase origin
    for (int i = 1; i <= 3 * CHK; i++) begin
      start = (i == 5);
      step();
      chk(i > 5 ? "R3 start ignored when armed" : "R4 hold normal", NORM);
    end
    start = 1'b0;
    for (int st = 0; st < 5; st++) begin
      for (int k = 1; k <= CHK; k++) begin
        int det, rem, degr;
        det  = (k == CHK) ? 2 * CHK : CHK;
        rem  = det - k;
        degr = 0;
        repeat (k - 1) step();
        strike = 5'(1 << st); step(); strike = '0;
        if (obs() !== NORM) degr++;
        chk("R5 stage effect", corrupt(st));
        for (int j = 1; j <= rem; j++) begin
          step();
          if (obs() !== NORM) degr++;
          if (j < rem) chk("R6 before check", corrupt(st));
          else         chk("R6 at check", ISOL);
        end
        for (int j = 1; j <= 5; j++) begin
          step();
          if (obs() !== NORM) degr++;
          chk("R7 isolated while reloading", ISOL);
        end
        step();
        chk("R7 back to normal", NORM);
        n_cmp++;
        if (degr > BUD) begin
          n_bad++;
          $display("FAIL R8 repair time: got %0d expected <= %0d", degr, BUD);
        end
      end
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule